// File: doc/BRIEF.md
# Decode-Stage Hazard and Stall Control

This block is the decode-stage pipeline controller for a five-stage in-order pipeline in which branches and jumps are resolved in decode. Each cycle it looks at the instructions in execute and memory and at the source registers of the instruction in decode. From these it decides whether fetch and decode must hold, whether a no-op bubble must enter execute, whether the fetched instruction must be squashed, and whether each branch-compare operand should come from the register file or from the memory-stage result.

All decisions except one are combinational and apply in the cycle their inputs are presented. The exception is a load followed directly by a branch that reads the loaded register. The loaded value cannot be forwarded to the decode comparator until it has left the memory stage. The block therefore keeps one bit of state, which records whether the instruction now in memory was a load. That bit stretches the stall to a second cycle.

The reset input is asynchronous and active low. It is released synchronously inside the block.

Top module: `hz_decode_ctrl`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero, and `ex_dst` equals `dec_src_a` or `dec_src_b`, a stall is raised in that cycle.
- R2: `pc_we` and `ifid_we` are 0 in every cycle with a stall and 1 in every cycle without one.
- R3: `idex_bubble` is 1 exactly in the cycles with a stall.
- R4: While `dec_is_branch` is 1, `cmp_fwd_a` (for `dec_src_a`) and `cmp_fwd_b` (for `dec_src_b`) are 1 when `mem_wr_en` is 1 and `mem_dst` is nonzero and equal to that source. Otherwise they are 0 (0 = register file, 1 = memory-stage result).
- R5: When `dec_is_branch` is 1, `ex_wr_en` is 1, and a nonzero `ex_dst` equals either branch source, a stall is raised. The same execute-stage write raises no stall when decode holds no branch.
- R6: Without a stall, `if_flush` is 1 when `dec_is_jump` is 1, or when `dec_is_branch` and `dec_br_taken` are both 1. Otherwise it is 0.
- R7: In a stall cycle, `if_flush` is 0 even if a jump or a taken branch sits in decode.
- R8: Consider a branch in decode that reads a register written by the instruction in memory, where that instruction was presented as a load (`ex_is_load` = 1) in the previous cycle. This case raises a stall. A load followed directly by such a branch therefore stalls for exactly two cycles, and the branch proceeds in the third.
- R9: A destination of register 0 never causes a stall or a forward select.
- R10: A non-load result in memory that feeds a branch source is forwarded with no stall.
- R11: During and just after reset, the memory stage is treated as holding no load, so a memory-stage match alone raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_is_load | input | 1 | Instruction in execute reads memory |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_dst | input | AW | Destination register of the instruction in execute |
| mem_wr_en | input | 1 | Instruction in memory writes a register |
| mem_dst | input | AW | Destination register of the instruction in memory |
| dec_src_a | input | AW | First source register of the instruction in decode |
| dec_src_b | input | AW | Second source register of the instruction in decode |
| dec_is_branch | input | 1 | Decode holds a conditional branch |
| dec_is_jump | input | 1 | Decode holds an unconditional jump |
| dec_br_taken | input | 1 | Branch compare says taken |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control bits entering execute |
| if_flush | output | 1 | Squash the fetched instruction into a no-op |
| cmp_fwd_a | output | 1 | Compare operand A from the memory-stage result |
| cmp_fwd_b | output | 1 | Compare operand B from the memory-stage result |

## Verification
Stall, freeze, bubble, flush and forward-select outputs are all due in the same cycle as the inputs that cause them. The one exception is the load-tracking bit, which affects outputs one rising edge after the load was presented in execute. The bench drives every vector on the falling edge and samples one nanosecond later, well before the next rising edge. Its reference model keeps its own copy of the previous cycle's load flag, updated at each rising edge, so that the second stall cycle of a load-then-branch pair is expected in the correct cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic {
    CMP_FROM_RF    = 1'b0,
    CMP_FROM_EXMEM = 1'b1
  } cmp_src_e;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hz_load_track.sv
module hz_load_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_is_load,
  output logic mem_is_load
);
  logic load_d;
  logic load_q;

  always_comb begin
    load_d = ex_is_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_d;
  end

  assign mem_is_load = load_q;
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  output logic          stall_o
);
  logic dst_live;
  logic hit_a;
  logic hit_b;

  always_comb begin
    dst_live = (ex_dst != '0);
    hit_a    = (ex_dst == src_a);
    hit_b    = (ex_dst == src_b);
    stall_o  = ex_is_load & dst_live & (hit_a | hit_b);
  end
endmodule

// File: rtl/hz_branch_chk.sv
module hz_branch_chk
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic               is_branch,
  input  logic               ex_wr_en,
  input  logic [AW-1:0]      ex_dst,
  input  logic               mem_wr_en,
  input  logic [AW-1:0]      mem_dst,
  input  logic               mem_is_load,
  input  logic [AW-1:0]      src_a,
  input  logic [AW-1:0]      src_b,
  output logic               stall_o,
  output logic [NUM_SRC-1:0] fwd_o
);
  logic [NUM_SRC-1:0][AW-1:0] srcs;
  logic [NUM_SRC-1:0]         ex_hit;
  logic [NUM_SRC-1:0]         mem_hit;
  logic                       ex_live;
  logic                       mem_live;

  assign srcs[0]  = src_a;
  assign srcs[1]  = src_b;
  assign ex_live  = ex_wr_en  & (ex_dst  != '0);
  assign mem_live = mem_wr_en & (mem_dst != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    cmp_src_e sel;
    assign ex_hit[g]  = ex_live  & (ex_dst  == srcs[g]);
    assign mem_hit[g] = mem_live & (mem_dst == srcs[g]);
    assign sel        = (is_branch & mem_hit[g]) ? CMP_FROM_EXMEM : CMP_FROM_RF;
    assign fwd_o[g]   = (sel == CMP_FROM_EXMEM);
  end

  always_comb begin
    stall_o = is_branch & ((|ex_hit) | (mem_is_load & (|mem_hit)));
  end
endmodule

// File: rtl/hz_decode_ctrl.sv
module hz_decode_ctrl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_is_load,
  input  logic          ex_wr_en,
  input  logic [AW-1:0] ex_dst,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] mem_dst,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic          dec_is_branch,
  input  logic          dec_is_jump,
  input  logic          dec_br_taken,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble,
  output logic          if_flush,
  output logic          cmp_fwd_a,
  output logic          cmp_fwd_b
);
  logic               rst_sync_n;
  logic               mem_is_load;
  logic               lu_stall;
  logic               br_stall;
  logic               stall;
  logic               redirect;
  logic [NUM_SRC-1:0] fwd;

  hz_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hz_load_track u_load_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ex_is_load  (ex_is_load),
    .mem_is_load (mem_is_load)
  );

  hz_load_use #(.AW(AW)) u_load_use (
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .src_a      (dec_src_a),
    .src_b      (dec_src_b),
    .stall_o    (lu_stall)
  );

  hz_branch_chk #(.AW(AW)) u_branch_chk (
    .is_branch   (dec_is_branch),
    .ex_wr_en    (ex_wr_en),
    .ex_dst      (ex_dst),
    .mem_wr_en   (mem_wr_en),
    .mem_dst     (mem_dst),
    .mem_is_load (mem_is_load),
    .src_a       (dec_src_a),
    .src_b       (dec_src_b),
    .stall_o     (br_stall),
    .fwd_o       (fwd)
  );

  always_comb begin
    stall       = lu_stall | br_stall;
    redirect    = dec_is_jump | (dec_is_branch & dec_br_taken);
    pc_we       = ~stall;
    ifid_we     = ~stall;
    idex_bubble = stall;
    if_flush    = redirect & ~stall;
    cmp_fwd_a   = fwd[0];
    cmp_fwd_b   = fwd[1];
  end
endmodule

// File: rtl/hz_decode_ctrl_chk.sv
module hz_decode_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_is_load,
  input logic [AW-1:0] ex_dst,
  input logic [AW-1:0] mem_dst,
  input logic [AW-1:0] dec_src_a,
  input logic [AW-1:0] dec_src_b,
  input logic          dec_is_jump,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_bubble,
  input logic          if_flush,
  input logic          cmp_fwd_a,
  input logic          cmp_fwd_b
);
  p_load_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst != '0 && (ex_dst == dec_src_a || ex_dst == dec_src_b))
      |-> idex_bubble);

  p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we));

  p_jump_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_is_jump && pc_we) |-> if_flush);

  p_stall_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> !if_flush);

  p_reg_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0 && mem_dst == '0) |-> (!idex_bubble && !cmp_fwd_a && !cmp_fwd_b));
endmodule

bind hz_decode_ctrl hz_decode_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ex_is_load  (ex_is_load),
  .ex_dst      (ex_dst),
  .mem_dst     (mem_dst),
  .dec_src_a   (dec_src_a),
  .dec_src_b   (dec_src_b),
  .dec_is_jump (dec_is_jump),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .idex_bubble (idex_bubble),
  .if_flush    (if_flush),
  .cmp_fwd_a   (cmp_fwd_a),
  .cmp_fwd_b   (cmp_fwd_b)
);

// File: tb/tb_hz_decode_ctrl.sv
module tb_hz_decode_ctrl;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ex_is_load, ex_wr_en, mem_wr_en;
  logic [AW-1:0] ex_dst, mem_dst, dec_src_a, dec_src_b;
  logic dec_is_branch, dec_is_jump, dec_br_taken;
  logic pc_we, ifid_we, idex_bubble, if_flush, cmp_fwd_a, cmp_fwd_b;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hz_decode_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ex_is_load(ex_is_load), .ex_wr_en(ex_wr_en), .ex_dst(ex_dst),
    .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_is_branch(dec_is_branch), .dec_is_jump(dec_is_jump), .dec_br_taken(dec_br_taken),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
    .if_flush(if_flush), .cmp_fwd_a(cmp_fwd_a), .cmp_fwd_b(cmp_fwd_b)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    ex_is_load = 0; ex_wr_en = 0; ex_dst = '0;
    mem_wr_en = 0; mem_dst = '0; dec_src_a = '0; dec_src_b = '0;
    dec_is_branch = 0; dec_is_jump = 0; dec_br_taken = 0;
  endtask

  task automatic next_cyc();
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic mq;
    rst_n = 0;
    clear_in();
    // R11: a load seen during reset is not tracked; memory match alone does not stall
    ex_is_load = 1;
    repeat (3) next_cyc();
    mem_wr_en = 1; mem_dst = 2'd1; dec_is_branch = 1; dec_src_a = 2'd1;
    #1;
    chk("R11 bubble in reset", idex_bubble, 1'b0);
    chk("R11 pc_we in reset", pc_we, 1'b1);
    chk("R11 fwd_a in reset", cmp_fwd_a, 1'b1);
    next_cyc();
    clear_in();
    rst_n = 1;
    repeat (4) next_cyc();
    mem_wr_en = 1; mem_dst = 2'd1; dec_is_branch = 1; dec_src_a = 2'd1;
    #1;
    chk("R11 bubble after reset", idex_bubble, 1'b0);
    next_cyc(); clear_in(); next_cyc();

    // R1 and R8: load then dependent branch -> two stall cycles
    ex_is_load = 1; ex_wr_en = 1; ex_dst = 2'd3; dec_is_branch = 1; dec_src_a = 2'd3;
    #1;
    chk("R1 load-use bubble", idex_bubble, 1'b1);
    chk("R2 pc_we frozen", pc_we, 1'b0);
    chk("R2 ifid_we frozen", ifid_we, 1'b0);
    next_cyc();
    clear_in(); dec_is_branch = 1; dec_src_a = 2'd3; mem_wr_en = 1; mem_dst = 2'd3;
    #1;
    chk("R8 second stall cycle", idex_bubble, 1'b1);
    chk("R4 fwd_a on mem match", cmp_fwd_a, 1'b1);
    next_cyc();
    clear_in(); dec_is_branch = 1; dec_src_a = 2'd3; dec_br_taken = 1;
    #1;
    chk("R8 third cycle proceeds", idex_bubble, 1'b0);
    chk("R6 taken branch flush", if_flush, 1'b1);
    next_cyc();

    // R10: ALU result in memory feeds branch -> forward, no stall
    clear_in(); mem_wr_en = 1; mem_dst = 2'd2; dec_is_branch = 1; dec_src_b = 2'd2;
    #1;
    chk("R10 no stall", idex_bubble, 1'b0);
    chk("R10 fwd_b", cmp_fwd_b, 1'b1);
    chk("R4 fwd_a stays rf", cmp_fwd_a, 1'b0);
    next_cyc();

    // R5 and R7
    clear_in(); ex_wr_en = 1; ex_dst = 2'd1; dec_is_branch = 1; dec_src_b = 2'd1;
    dec_br_taken = 1; dec_is_jump = 1;
    #1;
    chk("R5 alu-to-branch stall", idex_bubble, 1'b1);
    chk("R7 flush held by stall", if_flush, 1'b0);
    chk("R3 bubble on stall", idex_bubble, 1'b1);
    dec_is_branch = 0; dec_br_taken = 0;
    #1;
    chk("R5 no stall without branch", idex_bubble, 1'b0);
    chk("R6 jump flush", if_flush, 1'b1);
    next_cyc();

    // R9: register 0
    clear_in(); ex_is_load = 1; ex_wr_en = 1; mem_wr_en = 1; dec_is_branch = 1;
    #1;
    chk("R9 no stall on r0", idex_bubble, 1'b0);
    chk("R9 no fwd_a on r0", cmp_fwd_a, 1'b0);
    chk("R9 no fwd_b on r0", cmp_fwd_b, 1'b0);
    next_cyc();
    clear_in();
    next_cyc();

    // Near-exhaustive sweep with a reference model
    mq = 1'b0;
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      logic lu, bs, ls, fa, fb, st, fl;
      v = 14'(i);
      ex_is_load = v[0] ^ v[1]; ex_wr_en = v[1]; ex_dst = v[3:2];
      mem_wr_en = v[4]; mem_dst = v[6:5]; dec_src_a = v[8:7]; dec_src_b = v[10:9];
      dec_is_branch = v[11]; dec_is_jump = v[12]; dec_br_taken = v[13];
      lu = ex_is_load && ex_dst != 0 && (ex_dst == dec_src_a || ex_dst == dec_src_b);
      bs = dec_is_branch && ex_wr_en && ex_dst != 0 &&
           (ex_dst == dec_src_a || ex_dst == dec_src_b);
      fa = dec_is_branch && mem_wr_en && mem_dst != 0 && mem_dst == dec_src_a;
      fb = dec_is_branch && mem_wr_en && mem_dst != 0 && mem_dst == dec_src_b;
      ls = mq && (fa || fb);
      st = lu || bs || ls;
      fl = !st && (dec_is_jump || (dec_is_branch && dec_br_taken));
      #1;
      chk("R1 R5 R8 sweep pc_we (R2)", pc_we, !st);
      chk("R2 sweep ifid_we", ifid_we, !st);
      chk("R3 sweep bubble", idex_bubble, st);
      chk("R4 sweep fwd_a", cmp_fwd_a, fa);
      chk("R4 sweep fwd_b", cmp_fwd_b, fb);
      chk("R6 R7 sweep flush", if_flush, fl);
      mq = ex_is_load;
      next_cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule